// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block adds two packed integer operands lane by lane. Each lane is summed on its own, with no carry crossing into a neighbouring lane. A lane whose sum leaves the range of its type is clamped to the nearest limit rather than wrapped. The same datapath handles these cases:

- lanes of 8 or 16 bits;
- unsigned or two's-complement signed arithmetic;
- a 64-bit or a 128-bit operand width.

An execution pipeline presents both operands, the three mode selects and a valid strobe in one cycle. One clock edge later it receives the registered packed result together with an output valid. While the strobe is low the result register keeps its last value. The block raises no flags and keeps no status.

Top module: `sat_lane_adder`

## Requirements
- R1: Each lane of the result is the sum of the matching lanes of `op_a` and `op_b`. A carry out of a lane never reaches the next lane. In 16-bit mode a carry from the low byte into the high byte of the same lane is kept.
- R2: With `lane_word`=0 and `signed_mode`=0 (unsigned 8-bit lanes), any lane sum above 0xFF gives 0xFF.
- R3: With `lane_word`=1 and `signed_mode`=0 (unsigned 16-bit lanes), any lane sum above 0xFFFF gives 0xFFFF.
- R4: With `lane_word`=0 and `signed_mode`=1 (signed 8-bit lanes), a sum above +127 gives 0x7F and a sum below -128 gives 0x80.
- R5: With `lane_word`=1 and `signed_mode`=1 (signed 16-bit lanes), a sum above +32767 gives 0x7FFF and a sum below -32768 gives 0x8000.
- R6: With `wide_mode`=0 (64-bit width), only bits 63:0 are computed and `result[127:64]` is zero. With `wide_mode`=1, all 128 bits are computed.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result for that input appears on `result` in that same cycle.
- R8: While `in_valid` is low, `result` keeps its previous value, whatever the operand and mode inputs do.
- R9: While `rst_n` is low, `result` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| lane_word | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| signed_mode | input | 1 | 0: unsigned saturation, 1: signed saturation |
| wide_mode | input | 1 | 0: 64-bit width, 1: 128-bit width |
| op_a | input | 128 | First packed operand |
| op_b | input | 128 | Second packed operand |
| result | output | 128 | Registered packed saturated sum |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |

## Verification
Some properties are checked by the assertions on every cycle:
- the one-cycle valid timing;
- that the result holds while no input is valid;
- that the upper half is zero after a narrow operation;
- that an unsigned lane never comes out smaller than one of its addends;
- that two non-negative signed 16-bit lanes never produce a negative result.

The exact clamp values need the bench's directed scenarios, computed by its own lane model. The same holds for the boundary sums on either side of each limit and for the isolation of carries at lane edges.

// File: rtl/sat_lane_adder.sv
module sat_lane_adder #(
  parameter int WIDTH  = 128,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             lane_word,
  input  logic             signed_mode,
  input  logic             wide_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] result,
  output logic             out_valid
);
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int N_BYTES = WIDTH / BYTE_W;
  localparam int N_WORDS = WIDTH / WORD_W;
  localparam int HALF    = WIDTH / 2;

  logic [WIDTH-1:0] byte_res, word_res, full_res, next_res;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] a, b;
    logic [BYTE_W:0]   s;
    logic              ovf_s;
    assign a     = op_a[i*BYTE_W +: BYTE_W];
    assign b     = op_b[i*BYTE_W +: BYTE_W];
    assign s     = {1'b0, a} + {1'b0, b};
    assign ovf_s = (a[BYTE_W-1] == b[BYTE_W-1]) && (s[BYTE_W-1] != a[BYTE_W-1]);
    always_comb begin
      if (signed_mode)
        byte_res[i*BYTE_W +: BYTE_W] = ovf_s ? {a[BYTE_W-1], {(BYTE_W-1){~a[BYTE_W-1]}}}
                                             : s[BYTE_W-1:0];
      else
        byte_res[i*BYTE_W +: BYTE_W] = s[BYTE_W] ? {BYTE_W{1'b1}} : s[BYTE_W-1:0];
    end
  end

  for (genvar j = 0; j < N_WORDS; j++) begin : g_word
    logic [WORD_W-1:0] a, b;
    logic [WORD_W:0]   s;
    logic              ovf_s;
    assign a     = op_a[j*WORD_W +: WORD_W];
    assign b     = op_b[j*WORD_W +: WORD_W];
    assign s     = {1'b0, a} + {1'b0, b};
    assign ovf_s = (a[WORD_W-1] == b[WORD_W-1]) && (s[WORD_W-1] != a[WORD_W-1]);
    always_comb begin
      if (signed_mode)
        word_res[j*WORD_W +: WORD_W] = ovf_s ? {a[WORD_W-1], {(WORD_W-1){~a[WORD_W-1]}}}
                                             : s[WORD_W-1:0];
      else
        word_res[j*WORD_W +: WORD_W] = s[WORD_W] ? {WORD_W{1'b1}} : s[WORD_W-1:0];
    end
  end

  assign full_res = lane_word ? word_res : byte_res;
  assign next_res = wide_mode ? full_res : {{HALF{1'b0}}, full_res[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_mode) |=> (result[WIDTH-1:HALF] == '0));
  a_r2_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !signed_mode && !lane_word) |=>
      (result[BYTE_W-1:0] >= $past(op_a[BYTE_W-1:0])));
  a_r5_pos_stays_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_mode && lane_word && !op_a[WORD_W-1] && !op_b[WORD_W-1]) |=>
      !result[WORD_W-1]);
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && !out_valid));
endmodule

// File: tb/sim_sat_lane_adder.sv
`timescale 1ns/1ps
module sim_sat_lane_adder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, lane_word = 1'b0, signed_mode = 1'b0, wide_mode = 1'b1;
  logic [127:0] op_a = '0, op_b = '0;
  logic [127:0] result;
  logic         out_valid;
  int checks = 0, failures = 0;
  logic [127:0] last_exp = '0;

  always #2.5 clk = ~clk;

  sat_lane_adder u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_word(lane_word),
    .signed_mode(signed_mode), .wide_mode(wide_mode), .op_a(op_a), .op_b(op_b),
    .result(result), .out_valid(out_valid));

  function automatic longint sat_lane(longint x, longint y, int bits, bit sgn);
    longint span = longint'(1) << bits;
    longint lo = sgn ? -(span / 2) : 0;
    longint hi = sgn ? (span / 2 - 1) : (span - 1);
    longint xs = x, ys = y, s;
    if (sgn && x >= span / 2) xs = x - span;
    if (sgn && y >= span / 2) ys = y - span;
    s = xs + ys;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    if (s < 0) s = s + span;
    return s;
  endfunction

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b, bit w, bit s, bit wd);
    logic [127:0] r = '0;
    int lim = wd ? 128 : 64;
    if (w) begin
      for (int i = 0; i < lim / 16; i++)
        r[i*16 +: 16] = 16'(sat_lane(longint'(a[i*16 +: 16]), longint'(b[i*16 +: 16]), 16, s));
    end else begin
      for (int i = 0; i < lim / 8; i++)
        r[i*8 +: 8] = 8'(sat_lane(longint'(a[i*8 +: 8]), longint'(b[i*8 +: 8]), 8, s));
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [127:0] a, logic [127:0] b, bit w, bit s, bit wd, string req);
    logic [127:0] exp = model(a, b, w, s, wd);
    @(negedge clk);
    op_a = a; op_b = b; lane_word = w; signed_mode = s; wide_mode = wd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " R7 valid"}, 128'(out_valid), 128'd1);
    check(result == exp, req, result, exp);
    last_exp = exp;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(result == '0 && out_valid == 1'b0, "R9 reset", result, '0);
  endtask

  task automatic t_lane_isolation();
    run_op({16{8'h7F}}, {16{8'h01}}, 0, 0, 1, "R1 byte lanes");
    run_op({8{16'h00FF}}, {8{16'h0001}}, 1, 0, 1, "R1 word inner carry");
    run_op({16{8'h80}}, {16{8'h80}}, 0, 1, 1, "R1 R4 no cross carry");
  endtask

  task automatic t_unsigned_byte();
    run_op({16{8'hFF}}, {16{8'h01}}, 0, 0, 1, "R2 just over");
    run_op({8{16'hF00E}}, {8{16'h10F1}}, 0, 0, 1, "R2 mixed lanes");
  endtask

  task automatic t_unsigned_word();
    run_op({8{16'hFFFF}}, {8{16'h0001}}, 1, 0, 1, "R3 just over");
    run_op({4{32'h8000_7FFF}}, {4{32'h8000_8000}}, 1, 0, 1, "R3 edge exact");
  endtask

  task automatic t_signed_byte();
    run_op({16{8'h7F}}, {16{8'h01}}, 0, 1, 1, "R4 positive clamp");
    run_op({16{8'h80}}, {16{8'hFF}}, 0, 1, 1, "R4 negative clamp");
    run_op({8{16'h407E}}, {8{16'hC001}}, 0, 1, 1, "R4 in range");
  endtask

  task automatic t_signed_word();
    run_op({8{16'h7FFF}}, {8{16'h0001}}, 1, 1, 1, "R5 positive clamp");
    run_op({8{16'h8000}}, {8{16'h8000}}, 1, 1, 1, "R5 negative clamp");
    run_op({4{32'h7FFE_8001}}, {4{32'h0001_FFFF}}, 1, 1, 1, "R5 at limits");
  endtask

  task automatic t_narrow();
    run_op({128{1'b1}}, {128{1'b1}}, 0, 0, 0, "R6 narrow byte");
    run_op({8{16'h1234}}, {8{16'h7FFF}}, 1, 1, 0, "R6 narrow word");
  endtask

  task automatic t_hold();
    run_op({16{8'h11}}, {16{8'h22}}, 0, 0, 1, "R8 setup");
    @(negedge clk);
    op_a = {128{1'b1}}; op_b = {128{1'b1}}; lane_word = 1'b1; wide_mode = 1'b0;
    @(negedge clk);
    check(result == last_exp, "R8 hold", result, last_exp);
    check(out_valid == 1'b0, "R7 idle valid low", 128'(out_valid), '0);
  endtask

  task automatic t_mixed();
    logic [127:0] a = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [127:0] b = 128'h8F7E_6D5C_4B3A_2918_0716_2534_4352_6170;
    for (int m = 0; m < 8; m++) begin
      run_op(a, b, m[0], m[1], m[2], "R1 pattern");
      a = {a[126:0], a[127] ^ a[100]};
      b = {b[0], b[127:1]} ^ a;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_lane_isolation();
    t_unsigned_byte();
    t_unsigned_word();
    t_signed_byte();
    t_signed_word();
    t_narrow();
    t_hold();
    t_mixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule